// File: doc/BRIEF.md
# SMBus Bus Timeout Monitor

This block watches an SMBus clock line and data line that have already been synchronized into the system clock domain. It measures time in system clocks, with the thresholds given in microseconds and scaled by a clocks-per-microsecond parameter. It reports two conditions. The first is a fault flag, raised when the clock line has stayed low for too long. The second is a bus-free indication, raised when both lines have stayed high for long enough or when a STOP has been seen. The block never drives the bus.

When the fault flag rises, the block issues one reset pulse of configurable length for the local communication logic. The pulse comes one microsecond after the flag, which is well inside the window the bus rules allow for that reset.

A local master that wants to open a transfer raises a request. The monitor holds the request and answers with a one-cycle grant once the bus is free. START and STOP conditions are decoded only to track whether the bus is busy. No other protocol decoding is done.

Top module: `smb_idle_watch`

## Requirements
- R1: With LOW_LIM = LOW_TMO_US*CLK_PER_US, `low_tmo_o` rises after the clock edge that samples `scl_i` low for the (LOW_LIM+1)-th consecutive time.
- R2: `low_tmo_o` clears on any edge that samples `scl_i` high, or on an edge that samples `tmo_clr_i` high. A clear given while `scl_i` is still low holds until the clock line has gone high and then stayed low long enough again. Setting takes priority over clearing.
- R3: `comm_rst_o` rises exactly CLK_PER_US cycles after `low_tmo_o` rises and stays high for exactly RST_LEN cycles.
- R4: With FREE_LIM = FREE_US*CLK_PER_US, `bus_free_o` rises after the edge that samples both lines high for the (FREE_LIM+1)-th consecutive time.
- R5: A STOP sets `bus_free_o` on the next cycle. A STOP is `sda_i` going from 0 to 1 between two consecutive samples that both have `scl_i` high.
- R6: A START clears `bus_free_o` on the next cycle. A START is `sda_i` going from 1 to 0 between two consecutive samples that both have `scl_i` high. Any sample with `scl_i` low also clears `bus_free_o`.
- R7: A cycle with `start_req_i` high leaves a request pending. In the cycle after a pending request and `bus_free_o` are both seen high, `start_grant_o` pulses high for one cycle, and that pulse uses up the request.
- R8: After reset, all four outputs are low, and the previous samples of both lines are taken as high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Synchronized SMBus clock line |
| sda_i | input | 1 | Synchronized SMBus data line |
| start_req_i | input | 1 | Local master asks to generate a START |
| tmo_clr_i | input | 1 | Clears the low-timeout flag |
| low_tmo_o | output | 1 | Clock held low past the limit |
| comm_rst_o | output | 1 | Reset pulse for the communication logic |
| bus_free_o | output | 1 | Bus is idle |
| start_grant_o | output | 1 | One-cycle grant of a pending START request |

## Verification
Each output has a fixed latency counted from the input samples. The timeout flag follows the (LOW_LIM+1)-th low sample at the same edge. The free indication follows the (FREE_LIM+1)-th high sample, and a START, a STOP or a low clock line changes it one edge after it is seen. The reset pulse starts CLK_PER_US edges after the flag and lasts RST_LEN edges. A grant comes one edge after a pending request and the free indication are both present.

The bench drives its inputs on the falling clock edge and samples on the falling edge. Its model of the requirements updates on the same rising edge as the design, so every comparison falls in the cycle where the result is due. The directed steps use tick counts taken directly from these latencies.

// File: rtl/smb_watch_pkg.sv
// Package: shared types for the SMBus timeout monitor.
// Assumes: nothing beyond IEEE 1800-2017.
package smb_watch_pkg;
    typedef enum logic [1:0] {
        RS_IDLE  = 2'd0,
        RS_WAIT  = 2'd1,
        RS_PULSE = 2'd2
    } rst_state_e;
endpackage

// File: rtl/smb_line_edges.sv
// Module: smb_line_edges
// Keeps the previous sample of SCL and SDA and decodes START
// (SDA falling while SCL is high) and STOP (SDA rising while SCL is high).
// Assumes: the inputs are already synchronized to clk.
module smb_line_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic start_det_o,
    output logic stop_det_o
);
    logic scl_q, sda_q;

    // Store the previous line samples; both lines read as idle-high after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    // Decode the two conditions from the previous and current samples.
    always_comb begin
        start_det_o = scl_q && scl_i && sda_q && !sda_i;
        stop_det_o  = scl_q && scl_i && !sda_q && sda_i;
    end

    a_r6_no_both_conditions: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_det_o && stop_det_o));
endmodule

// File: rtl/smb_run_timer.sv
// Module: smb_run_timer
// Counts consecutive cycles that run_i is high. When the count reaches
// LIMIT, it gives a one-cycle hit and then saturates so the hit cannot
// repeat during the same run.
// Assumes: LIMIT >= 1; clear_i or a low run_i restarts the count.
module smb_run_timer #(
    parameter int LIMIT = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic clear_i,
    output logic hit_o
);
    localparam int SAT = LIMIT + 1;
    localparam int W   = $clog2(SAT + 1);
    localparam logic [W-1:0] LIM_W = W'(LIMIT);
    localparam logic [W-1:0] SAT_W = W'(SAT);

    logic [W-1:0] cnt_q;

    // Run-length counter with restart and saturation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear_i || !run_i) begin
            cnt_q <= '0;
        end else if (cnt_q != SAT_W) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Hit on the edge that sees the (LIMIT+1)-th consecutive run cycle.
    assign hit_o = run_i && !clear_i && (cnt_q == LIM_W);

    a_r1_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= SAT_W);
    a_r4_hit_single: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |=> !hit_o);
endmodule

// File: rtl/smb_rst_seq.sv
// Module: smb_rst_seq
// After a trigger, waits DELAY cycles and then drives rst_o high for
// LEN cycles. A new trigger restarts the wait.
// Assumes: DELAY >= 1 and LEN >= 1.
module smb_rst_seq
    import smb_watch_pkg::*;
#(
    parameter int DELAY = 4,
    parameter int LEN   = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    output logic rst_o
);
    localparam int MAXV = (DELAY > LEN) ? DELAY : LEN;
    localparam int W    = $clog2(MAXV + 1);
    localparam logic [W-1:0] DLY_END = W'(DELAY - 1);
    localparam logic [W-1:0] LEN_END = W'(LEN - 1);

    rst_state_e   state_q;
    logic [W-1:0] cnt_q;

    // Three-phase sequencer: idle, wait for the delay, then the pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RS_IDLE;
            cnt_q   <= '0;
        end else if (trig_i) begin
            state_q <= RS_WAIT;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                RS_WAIT: begin
                    if (cnt_q == DLY_END) begin
                        state_q <= RS_PULSE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                RS_PULSE: begin
                    if (cnt_q == LEN_END) begin
                        state_q <= RS_IDLE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    state_q <= RS_IDLE;
                    cnt_q   <= '0;
                end
            endcase
        end
    end

    assign rst_o = (state_q == RS_PULSE);

    a_r3_pulse_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RS_PULSE) |-> (cnt_q <= LEN_END));
    a_r3_pulse_follows_wait: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_o) |-> ($past(state_q) == RS_WAIT));
endmodule

// File: rtl/smb_idle_watch.sv
// Module: smb_idle_watch (top)
// SMBus timeout monitor. It raises a flag when SCL has been held low too
// long, sends a reset pulse one microsecond after that flag, tracks whether
// the bus is free (a STOP, or both lines high long enough), and grants a
// queued master START once the bus is free.
// Assumes: scl_i and sda_i are synchronized; it never drives the bus.
module smb_idle_watch #(
    parameter int CLK_PER_US = 250,
    parameter int LOW_TMO_US = 25000,
    parameter int FREE_US    = 50,
    parameter int RST_LEN    = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic start_req_i,
    input  logic tmo_clr_i,
    output logic low_tmo_o,
    output logic comm_rst_o,
    output logic bus_free_o,
    output logic start_grant_o
);
    localparam int LOW_LIM  = LOW_TMO_US * CLK_PER_US;
    localparam int FREE_LIM = FREE_US * CLK_PER_US;

    logic start_det, stop_det;
    logic low_hit, high_hit;
    logic flag_q, free_q, pend_q, grant_q;
    logic grant_fire;

    smb_line_edges u_edges (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl_i),
        .sda_i       (sda_i),
        .start_det_o (start_det),
        .stop_det_o  (stop_det)
    );

    smb_run_timer #(.LIMIT(LOW_LIM)) u_low_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (!scl_i),
        .clear_i (start_det),
        .hit_o   (low_hit)
    );

    smb_run_timer #(.LIMIT(FREE_LIM)) u_high_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (scl_i && sda_i),
        .clear_i (start_det),
        .hit_o   (high_hit)
    );

    smb_rst_seq #(.DELAY(CLK_PER_US), .LEN(RST_LEN)) u_rst_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig_i (low_hit),
        .rst_o  (comm_rst_o)
    );

    // Timeout flag: set on a low-timer hit, cleared by software or by SCL high.
    always_ff @(posedge clk) begin
        if (!rst_n)                  flag_q <= 1'b0;
        else if (low_hit)            flag_q <= 1'b1;
        else if (tmo_clr_i || scl_i) flag_q <= 1'b0;
    end

    // Bus-free state: set by a STOP or the high timeout, cleared by a START or SCL low.
    always_ff @(posedge clk) begin
        if (!rst_n)                     free_q <= 1'b0;
        else if (stop_det || high_hit)  free_q <= 1'b1;
        else if (start_det || !scl_i)   free_q <= 1'b0;
    end

    assign grant_fire = pend_q && free_q;

    // Pending START request and its one-cycle grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= 1'b0;
            grant_q <= 1'b0;
        end else begin
            pend_q  <= start_req_i || (pend_q && !grant_fire);
            grant_q <= grant_fire;
        end
    end

    assign low_tmo_o     = flag_q;
    assign bus_free_o    = free_q;
    assign start_grant_o = grant_q;

    a_r1_flag_rises_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(low_tmo_o) |-> !$past(scl_i));
    a_r2_flag_drops_high: assert property (@(posedge clk) disable iff (!rst_n)
        scl_i |=> !low_tmo_o);
    a_r5_stop_frees: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> bus_free_o);
    a_r6_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !bus_free_o);
    a_r7_grant_needs_free: assert property (@(posedge clk) disable iff (!rst_n)
        start_grant_o |-> $past(bus_free_o));
    a_r7_grant_single: assert property (@(posedge clk) disable iff (!rst_n)
        start_grant_o |=> !start_grant_o);
endmodule

// File: tb/sim_smb_idle_watch.sv
`timescale 1ns/1ps
module sim_smb_idle_watch;
    localparam int CPU   = 4;
    localparam int LOWUS = 30;
    localparam int FRUS  = 5;
    localparam int RLEN  = 3;
    localparam int LLIM  = LOWUS * CPU;
    localparam int FLIM  = FRUS * CPU;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1, sda = 1'b1, req = 1'b0, clr = 1'b0;
    logic tmo, crst, free, grant;

    int checks = 0, fails = 0;
    bit done = 1'b0, live = 1'b0;

    smb_idle_watch #(.CLK_PER_US(CPU), .LOW_TMO_US(LOWUS), .FREE_US(FRUS), .RST_LEN(RLEN)) u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
        .start_req_i(req), .tmo_clr_i(clr),
        .low_tmo_o(tmo), .comm_rst_o(crst), .bus_free_o(free), .start_grant_o(grant)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Reference model built from the requirements.
    int cyc = 0, low_run = 0, hi_run = 0, evt = -100000;
    bit m_pscl = 1, m_psda = 1, m_flag = 0, m_free = 0, m_pend = 0, m_grant = 0;

    function automatic bit exp_rst(input int c, input int e);
        return (c >= e + CPU) && (c <= e + CPU + RLEN - 1);
    endfunction

    always @(posedge clk) begin
        bit st, sp, fire;
        cyc++;
        if (!rst_n) begin
            m_pscl = 1; m_psda = 1; low_run = 0; hi_run = 0;
            m_flag = 0; m_free = 0; m_pend = 0; m_grant = 0; evt = -100000;
        end else begin
            st = m_pscl && scl && m_psda && !sda;
            sp = m_pscl && scl && !m_psda && sda;
            low_run = scl ? 0 : low_run + 1;
            hi_run  = (scl && sda) ? hi_run + 1 : 0;
            if (!scl && low_run == LLIM + 1) begin m_flag = 1; evt = cyc; end
            else if (clr || scl) m_flag = 0;
            fire = m_pend && m_free;
            m_grant = fire;
            m_pend = req || (m_pend && !fire);
            if (sp || hi_run == FLIM + 1) m_free = 1;
            else if (st || !scl) m_free = 0;
            m_pscl = scl; m_psda = sda;
        end
    end

    // Compare every output to the model in every cycle, away from the active edge.
    always @(negedge clk) begin
        if (live) begin
            chk(tmo == m_flag, "R1,R2 low_tmo_o", tmo, m_flag);
            chk(crst == exp_rst(cyc, evt), "R3 comm_rst_o", crst, exp_rst(cyc, evt));
            chk(free == m_free, "R4,R5,R6 bus_free_o", free, m_free);
            chk(grant == m_grant, "R7 start_grant_o", grant, m_grant);
        end
    end

    initial begin
        #700000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        tick(3);
        // R8: reset state
        chk(tmo == 0 && crst == 0 && free == 0 && grant == 0, "R8 reset outputs", {tmo, crst, free, grant}, 0);
        rst_n = 1'b1; live = 1'b1;
        // R4: free after FLIM+1 high samples
        tick(FLIM);  chk(free == 0, "R4 not yet free", free, 0);
        tick(1);     chk(free == 1, "R4 free", free, 1);
        // R7: grant while free
        req = 1; tick(1); req = 0;
        chk(grant == 0, "R7 grant latency", grant, 0);
        tick(1); chk(grant == 1, "R7 grant", grant, 1);
        tick(1); chk(grant == 0, "R7 grant one cycle", grant, 0);
        // R6: START
        sda = 0; tick(1); chk(free == 0, "R6 start busy", free, 0);
        // R1 / R3: long low
        scl = 0; tick(LLIM); chk(tmo == 0, "R1 not yet", tmo, 0);
        tick(1); chk(tmo == 1, "R1 timeout", tmo, 1);
        tick(CPU - 1); chk(crst == 0, "R3 before pulse", crst, 0);
        tick(1); chk(crst == 1, "R3 pulse start", crst, 1);
        tick(RLEN - 1); chk(crst == 1, "R3 pulse last", crst, 1);
        tick(1); chk(crst == 0, "R3 pulse end", crst, 0);
        // R2: software clear holds while low
        clr = 1; tick(1); clr = 0; chk(tmo == 0, "R2 clear", tmo, 0);
        tick(8); chk(tmo == 0, "R2 stays clear", tmo, 0);
        // R5: STOP
        scl = 1; tick(3); chk(free == 0, "R5 no stop yet", free, 0);
        sda = 1; tick(1); chk(free == 1, "R5 stop frees", free, 1);
        // R6: SCL low without START
        scl = 0; tick(1); chk(free == 0, "R6 scl low busy", free, 0);
        // R7: request waits for free
        req = 1; tick(1); req = 0; tick(5);
        chk(grant == 0, "R7 held while busy", grant, 0);
        scl = 1; tick(FLIM); chk(free == 0 && grant == 0, "R7 still waiting", {free, grant}, 0);
        tick(1); chk(free == 1 && grant == 0, "R4 free before grant", {free, grant}, 2);
        tick(1); chk(grant == 1, "R7 late grant", grant, 1);
        tick(1); chk(grant == 0, "R7 late grant one cycle", grant, 0);
        // R2: SCL high clears flag
        sda = 0; tick(1); scl = 0; tick(LLIM + 1); chk(tmo == 1, "R1 timeout again", tmo, 1);
        scl = 1; tick(1); chk(tmo == 0, "R2 clear on scl high", tmo, 0);
        tick(CPU + RLEN + 2);
        // Random traffic checked by the model every cycle
        for (int i = 0; i < 500; i++) begin
            int len;
            scl = 1'($urandom % 2);
            sda = 1'($urandom % 2);
            len = ($urandom % 10 == 0) ? LLIM + int'($urandom % 30) : 1 + int'($urandom % (FLIM + 10));
            req = ($urandom % 6 == 0);
            clr = ($urandom % 8 == 0);
            tick(1);
            req = 0; clr = 0;
            if (len > 1) tick(len - 1);
        end
        tick(4);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule